// File: doc/BRIEF.md
# Range-Gated Sample Strobe with Packet Buffer

This block sits at the output of a pulsed-radar receiver's decimator. It decides which decimated samples move on to the host. A phase counter repeats every inter-pulse period, which is programmed as a number of clock cycles. Inside each period a receive window opens at a near-range delay and closes at a far-range delay. A decimator strobe is qualified only while that window is open. Samples outside the window are dropped, not replaced by zeros, so the output data rate follows the window's duty cycle.

Qualified samples are written into a receive buffer that holds two packets. Once a packet's worth of samples is present, a packet-ready flag rises. It stays up until the consumer has popped one full packet. The buffer is flushed at the start and at the end of every run, so the first sample of a run is always the first in-window sample of that run and no stale data survives. If a qualified sample finds the buffer full, a sticky overrun flag is set.

Top module: `range_gate_strobe`

## Requirements
- R1: `smp_vld_o` equals `gate_o AND dec_stb` in the same cycle. Only qualified samples enter the buffer, so samples outside the window are never stored.
- R2: The clock edge that first sees `run_en` high (the run start) sets the period phase to 0. In the k-th cycle after that edge (k = 0 directly after it), the phase is k mod IPP.
- R3: `gate_o` is high exactly when start ≤ phase < stop. When stop ≤ start, the gate never opens.
- R4: The IPP, start and stop inputs are captured only while the block is idle. Changing them during a run has no effect until the next run start.
- R5: Stored samples are read oldest first. `rd_data_o` shows the oldest sample, and `rd_en` pops one sample only while `pkt_rdy_o` is high. Otherwise `rd_en` is ignored.
- R6: `pkt_rdy_o` rises one cycle after the buffer level first reaches PKT_LEN. It stays high until PKT_LEN pops have been accepted, and then drops for at least one cycle.
- R7: A qualified sample that arrives while the level is 2·PKT_LEN is dropped and sets `overrun_o`. The flag stays high for the rest of the run. A pop in the same cycle does not make room for it.
- R8: The run-start edge and the run-stop edge (the first edge that sees `run_en` low after a run) each empty the buffer and clear `pkt_rdy_o` and `overrun_o`. No sample from an earlier run is ever read.
- R9: After reset, `gate_o`, `smp_vld_o`, `pkt_rdy_o` and `overrun_o` are all low, whatever `dec_stb` does.
- R10: `gate_o` and `smp_vld_o` are low in every cycle in which `run_en` is low, including the cycle in which a run is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Acquisition run enable |
| dec_stb | input | 1 | Decimator output strobe |
| dec_data | input | DATA_W | Decimated sample |
| cfg_ipp | input | CNT_W | Inter-pulse period in clock cycles |
| cfg_start | input | CNT_W | Window open delay (near range) |
| cfg_stop | input | CNT_W | Window close delay (far range) |
| rd_en | input | 1 | Consumer pop request |
| gate_o | output | 1 | Range window open |
| smp_vld_o | output | 1 | Qualified sample strobe |
| pkt_rdy_o | output | 1 | A full packet is ready to be read |
| rd_data_o | output | DATA_W | Oldest buffered sample |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
A qualified write and a consumer pop can fall in the same cycle. This matters most when the buffer is exactly full: the pop must not make room for the write. The bench provokes this by sweeping every start/stop pair of a short period under several strobe patterns, some with the consumer draining and some without. It judges the outcome against an arithmetic model of the level, the packet-ready flag and the overrun flag, and compares every popped value with the model's queue.

// File: rtl/rgs_pkg.sv
package rgs_pkg;

  typedef enum logic [1:0] {
    EVT_IDLE   = 2'd0,
    EVT_START  = 2'd1,
    EVT_ACTIVE = 2'd2,
    EVT_STOP   = 2'd3
  } run_evt_e;

  // Classify the current cycle from the enable and its registered copy.
  function automatic run_evt_e run_event(input logic en, input logic en_q);
    run_evt_e evt;
    unique case ({en, en_q})
      2'b10:   evt = EVT_START;
      2'b01:   evt = EVT_STOP;
      2'b11:   evt = EVT_ACTIVE;
      default: evt = EVT_IDLE;
    endcase
    return evt;
  endfunction

endpackage

// File: rtl/rgs_period_gate.sv
module rgs_period_gate #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_cfg,
  input  logic             clear,
  input  logic             advance,
  input  logic             en,
  input  logic [CNT_W-1:0] cfg_ipp,
  input  logic [CNT_W-1:0] cfg_start,
  input  logic [CNT_W-1:0] cfg_stop,
  output logic             gate
);

  logic [CNT_W-1:0] ipp_q, ipp_d;
  logic [CNT_W-1:0] start_q, start_d;
  logic [CNT_W-1:0] stop_q, stop_d;
  logic [CNT_W-1:0] phase_q, phase_d;
  logic             wrap;

  assign wrap = (phase_q == ipp_q - 1'b1);

  always_comb begin
    ipp_d   = ipp_q;
    start_d = start_q;
    stop_d  = stop_q;
    if (load_cfg) begin
      ipp_d   = cfg_ipp;
      start_d = cfg_start;
      stop_d  = cfg_stop;
    end
  end

  always_comb begin
    phase_d = phase_q;
    if (clear) begin
      phase_d = '0;
    end else if (advance) begin
      phase_d = wrap ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipp_q   <= '0;
      start_q <= '0;
      stop_q  <= '0;
      phase_q <= '0;
    end else begin
      ipp_q   <= ipp_d;
      start_q <= start_d;
      stop_q  <= stop_d;
      phase_q <= phase_d;
    end
  end

  assign gate = en && (phase_q >= start_q) && (phase_q < stop_q);

endmodule

// File: rtl/rgs_sample_buf.sv
module rgs_sample_buf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 512,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level,
  output logic              overrun
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q, wptr_d;
  logic [PTR_W-1:0]  rptr_q, rptr_d;
  logic [LVL_W-1:0]  level_q, level_d;
  logic              ovr_q, ovr_d;
  logic              full;
  logic              wr_ok;

  assign full  = (level_q == LVL_W'(DEPTH));
  assign wr_ok = wr_req && !full && !flush;

  always_comb begin
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    level_d = level_q;
    ovr_d   = ovr_q;
    if (flush) begin
      wptr_d  = '0;
      rptr_d  = '0;
      level_d = '0;
      ovr_d   = 1'b0;
    end else begin
      if (wr_ok) begin
        wptr_d = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      end
      if (rd_pop) begin
        rptr_d = (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      end
      level_d = level_q + LVL_W'(wr_ok) - LVL_W'(rd_pop);
      if (wr_req && full) begin
        ovr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      level_q <= level_d;
      ovr_q   <= ovr_d;
    end
  end

  // Storage array: no reset, written only on an accepted sample.
  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[wptr_q] <= wr_data;
    end
  end

  assign rd_data = mem[rptr_q];
  assign level   = level_q;
  assign overrun = ovr_q;

endmodule

// File: rtl/rgs_pkt_ctrl.sv
module rgs_pkt_ctrl #(
  parameter int PKT_LEN = 256,
  parameter int LVL_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [LVL_W-1:0] level,
  input  logic             rd_req,
  output logic             pkt_rdy,
  output logic             rd_fire
);

  localparam int RC_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;

  logic            open_q, open_d;
  logic [RC_W-1:0] rcnt_q, rcnt_d;
  logic            last_pop;

  assign rd_fire  = rd_req && open_q && !flush;
  assign last_pop = (rcnt_q == RC_W'(PKT_LEN - 1));

  always_comb begin
    open_d = open_q;
    rcnt_d = rcnt_q;
    if (flush) begin
      open_d = 1'b0;
      rcnt_d = '0;
    end else if (open_q) begin
      if (rd_fire) begin
        if (last_pop) begin
          open_d = 1'b0;
          rcnt_d = '0;
        end else begin
          rcnt_d = rcnt_q + 1'b1;
        end
      end
    end else if (level >= LVL_W'(PKT_LEN)) begin
      open_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rcnt_q <= '0;
    end else begin
      open_q <= open_d;
      rcnt_q <= rcnt_d;
    end
  end

  assign pkt_rdy = open_q;

endmodule

// File: rtl/range_gate_strobe.sv
module range_gate_strobe
  import rgs_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 16,
  parameter int PKT_LEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              dec_stb,
  input  logic [DATA_W-1:0] dec_data,
  input  logic [CNT_W-1:0]  cfg_ipp,
  input  logic [CNT_W-1:0]  cfg_start,
  input  logic [CNT_W-1:0]  cfg_stop,
  input  logic              rd_en,
  output logic              gate_o,
  output logic              smp_vld_o,
  output logic              pkt_rdy_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              overrun_o
);

  localparam int DEPTH = 2 * PKT_LEN;
  localparam int LVL_W = $clog2(DEPTH + 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  // Run tracking.
  logic     run_q, run_d;
  run_evt_e evt;
  logic     flush;
  logic     load_cfg;
  logic     active;

  assign run_d = run_en;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  assign evt      = run_event(run_en, run_q);
  assign flush    = (evt == EVT_START) || (evt == EVT_STOP);
  assign load_cfg = !run_q;
  assign active   = (evt == EVT_ACTIVE);

  logic             gate;
  logic             rd_fire;
  logic [LVL_W-1:0] buf_level;

  rgs_period_gate #(.CNT_W(CNT_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_cfg (load_cfg),
    .clear    (evt == EVT_START),
    .advance  (active),
    .en       (active),
    .cfg_ipp  (cfg_ipp),
    .cfg_start(cfg_start),
    .cfg_stop (cfg_stop),
    .gate     (gate)
  );

  assign gate_o    = gate;
  assign smp_vld_o = gate && dec_stb;

  rgs_sample_buf #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .LVL_W (LVL_W)
  ) u_buf (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .flush  (flush),
    .wr_req (smp_vld_o),
    .wr_data(dec_data),
    .rd_pop (rd_fire),
    .rd_data(rd_data_o),
    .level  (buf_level),
    .overrun(overrun_o)
  );

  rgs_pkt_ctrl #(
    .PKT_LEN(PKT_LEN),
    .LVL_W  (LVL_W)
  ) u_pkt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .flush  (flush),
    .level  (buf_level),
    .rd_req (rd_en),
    .pkt_rdy(pkt_rdy_o),
    .rd_fire(rd_fire)
  );

endmodule

// File: rtl/range_gate_strobe_chk.sv
module rgs_chk #(
  parameter int PKT_LEN = 256,
  parameter int DEPTH   = 2 * PKT_LEN,
  parameter int LVL_W   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             dec_stb,
  input logic             rd_en,
  input logic             gate_o,
  input logic             smp_vld_o,
  input logic             pkt_rdy_o,
  input logic             overrun_o,
  input logic [LVL_W-1:0] level
);

  // R1
  strobe_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld_o |-> (gate_o && dec_stb));

  // R10
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !gate_o);

  // R8
  start_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |=> (!pkt_rdy_o && !overrun_o && level == '0));

  // R8
  stop_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_en) |=> (!pkt_rdy_o && !overrun_o && level == '0));

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && run_en) |=> overrun_o);

  // R6
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_rdy_o && !rd_en && run_en) |=> pkt_rdy_o);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

endmodule

bind range_gate_strobe rgs_chk #(.PKT_LEN(PKT_LEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .dec_stb  (dec_stb),
  .rd_en    (rd_en),
  .gate_o   (gate_o),
  .smp_vld_o(smp_vld_o),
  .pkt_rdy_o(pkt_rdy_o),
  .overrun_o(overrun_o),
  .level    (buf_level)
);

// File: tb/range_gate_strobe_bench.sv
`timescale 1ns/1ps
module range_gate_strobe_bench;

  localparam int CNT_W   = 6;
  localparam int DATA_W  = 8;
  localparam int PKT_LEN = 4;
  localparam int DEPTH   = 2 * PKT_LEN;

  logic              clk;
  logic              rst_n;
  logic              run_en;
  logic              dec_stb;
  logic [DATA_W-1:0] dec_data;
  logic [CNT_W-1:0]  cfg_ipp, cfg_start, cfg_stop;
  logic              rd_en;
  logic              gate_o, smp_vld_o, pkt_rdy_o, overrun_o;
  logic [DATA_W-1:0] rd_data_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int run_id = 0;

  // Bench model state.
  logic [DATA_W-1:0] mq[$];
  bit m_open;
  int m_rdc;
  bit m_ovr;

  range_gate_strobe #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .PKT_LEN(PKT_LEN)
  ) u_range_gate_strobe (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .dec_stb(dec_stb),
    .dec_data(dec_data), .cfg_ipp(cfg_ipp), .cfg_start(cfg_start),
    .cfg_stop(cfg_stop), .rd_en(rd_en), .gate_o(gate_o),
    .smp_vld_o(smp_vld_o), .pkt_rdy_o(pkt_rdy_o),
    .rd_data_o(rd_data_o), .overrun_o(overrun_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0h exp=%0h (run %0d, t=%0t)", req, act, exp, run_id, $time);
    end
  endtask

  task automatic run_case(input int ipp, input int st, input int sp,
                          input int mode, input int ncyc);
    bit stb;
    bit exp_gate;
    bit vld;
    bit fire;
    int lvl;
    int ph;
    logic [DATA_W-1:0] dat;
    run_id = run_id + 1;
    @(negedge clk);
    cfg_ipp   = CNT_W'(ipp);
    cfg_start = CNT_W'(st);
    cfg_stop  = CNT_W'(sp);
    run_en    = 1'b1;
    dec_stb   = 1'b0;
    rd_en     = 1'b0;
    @(posedge clk);
    mq.delete();
    m_open = 0;
    m_rdc  = 0;
    m_ovr  = 0;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      if (k == ncyc / 2) begin
        // R4: reprogramming mid-run must not change this run
        cfg_ipp   = CNT_W'(2);
        cfg_start = CNT_W'(0);
        cfg_stop  = CNT_W'(2);
      end
      case (mode)
        0:       stb = 1'b1;
        1:       stb = (k % 2) == 0;
        default: stb = ((k * 5) % 7) < 3;
      endcase
      dat      = DATA_W'(run_id * 16 + k);
      dec_stb  = stb;
      dec_data = dat;
      rd_en    = (mode != 0) && m_open;
      #1;
      ph       = k % ipp;
      exp_gate = (ph >= st) && (ph < sp);
      chk((k >= ncyc / 2) ? "R4 gate" : "R2 R3 gate", 32'(gate_o), 32'(exp_gate));
      chk("R1 smp_vld", 32'(smp_vld_o), 32'(exp_gate && stb));
      chk("R6 pkt_rdy", 32'(pkt_rdy_o), 32'(m_open));
      chk("R7 overrun", 32'(overrun_o), 32'(m_ovr));
      if (rd_en && mq.size() > 0)
        chk("R5 R8 rd_data", 32'(rd_data_o), 32'(mq[0]));
      // model update at the coming edge
      vld  = exp_gate && stb;
      fire = rd_en && m_open;
      lvl  = mq.size();
      if (fire) void'(mq.pop_front());
      if (vld) begin
        if (lvl < DEPTH) mq.push_back(dat);
        else m_ovr = 1;
      end
      if (m_open) begin
        if (fire) begin
          if (m_rdc == PKT_LEN - 1) begin
            m_open = 0;
            m_rdc  = 0;
          end else begin
            m_rdc = m_rdc + 1;
          end
        end
      end else if (lvl >= PKT_LEN) begin
        m_open = 1;
      end
    end
    // Stop the run with the strobe still firing.
    @(negedge clk);
    run_en  = 1'b0;
    rd_en   = 1'b0;
    dec_stb = 1'b1;
    #1;
    chk("R10 gate at stop", 32'(gate_o), 32'd0);
    chk("R10 smp_vld at stop", 32'(smp_vld_o), 32'd0);
    @(negedge clk);
    #1;
    chk("R8 pkt_rdy after stop", 32'(pkt_rdy_o), 32'd0);
    chk("R8 overrun after stop", 32'(overrun_o), 32'd0);
    chk("R10 gate idle", 32'(gate_o), 32'd0);
    dec_stb = 1'b0;
  endtask

  initial begin
    rst_n     = 1'b0;
    run_en    = 1'b0;
    dec_stb   = 1'b0;
    dec_data  = '0;
    cfg_ipp   = '0;
    cfg_start = '0;
    cfg_stop  = '0;
    rd_en     = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n   = 1'b1;
    dec_stb = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R9 gate", 32'(gate_o), 32'd0);
    chk("R9 smp_vld", 32'(smp_vld_o), 32'd0);
    chk("R9 pkt_rdy", 32'(pkt_rdy_o), 32'd0);
    chk("R9 overrun", 32'(overrun_o), 32'd0);
    dec_stb = 1'b0;

    // Sweep every window of a six-cycle period under three strobe patterns.
    for (int mode = 0; mode < 3; mode++)
      for (int st = 0; st <= 6; st++)
        for (int sp = 0; sp <= 6; sp++)
          run_case(6, st, sp, mode, 36);

    // Degenerate and short periods.
    run_case(1, 0, 1, 0, 30);
    run_case(1, 0, 1, 1, 40);
    run_case(3, 1, 3, 2, 40);
    run_case(3, 2, 1, 0, 20);
    run_case(5, 0, 5, 1, 60);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule